// File: doc/BRIEF.md
# Centralized Scoreboard Issue and Hazard Controller

This block is the control core of a scoreboarded execution back end. An in-order stream of decoded instructions arrives one at a time at its head: each carries an operation class, a destination register and two source register numbers. The controller assigns each instruction to a free functional unit and tracks it through four phases: issue, operand read, execution and result write. It detects structural, write-after-write, read-after-write and write-after-read hazards, and it stalls the phase that would break them. Results are never forwarded.

The functional units are outside the block. Each unit is told when it was granted an instruction. It is told when it may read its operands, which starts its execution. It is told when it may write its result. The unit answers with a one-cycle done pulse when its result is ready. A status record per unit holds the destination, the sources, the producing unit of each unready source, and one flag per source that means "available but not yet read". A register result table maps each register to its pending producer.

Top module: `sb_ctrl`

## Requirements
- R1: Instructions issue strictly in program order. The head is accepted only in a cycle with `in_valid_i` and `in_ready_o` both high. A later instruction cannot issue while the head is blocked, and once the head issues the next one can issue in the following cycle.
- R2: Class codes are 0 integer, 1 FP add, 2 FP multiply and 3 FP divide. Unit bit positions in `grant_o`, `read_o`, `done_i` and `wb_o` are 0 integer, 1 add, 2 and 3 the two multipliers, and 4 divide. An instruction whose unit class has no idle unit is held (structural hazard).
- R3: A multiply goes to the lowest-numbered idle multiplier, so two back-to-back multiplies issue in consecutive cycles on bits 2 and 3. `grant_o` has at most one bit set.
- R4: An instruction whose destination is the destination of any issued, unfinished instruction is held until that instruction has written back (no WAW).
- R5: Operands are read only after every pending producer of a source has written back. The read happens in the cycle after the producer's write cycle, never in the same cycle (no forwarding).
- R6: An instruction with no pending source reads its operands in the cycle after it was granted.
- R7: With no WAR conflict, `wb_o` rises in the cycle after the unit's `done_i` pulse.
- R8: A result write is held while an earlier-issued unit still has an unread source equal to the destination being written. It proceeds in the cycle after that unit's read.
- R9: In the write cycle the unit's busy state and its register table entry are released, so the unit or the register can be granted again in the next cycle.
- R10: After reset `in_ready_o` is high and `grant_o`, `read_o` and `wb_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Head instruction present |
| in_cls_i | input | 2 | Operation class of the head |
| in_dst_i | input | RW | Destination register of the head |
| in_src1_i | input | RW | First source register |
| in_src2_i | input | RW | Second source register |
| in_ready_o | output | 1 | Head can issue this cycle |
| grant_o | output | NU | One-hot unit granted the head this cycle |
| read_o | output | NU | Unit may read operands and start executing |
| done_i | input | NU | One-cycle pulse: unit result ready |
| wb_o | output | NU | Unit writes its result this cycle |

## Verification
The assertions take for granted that each unit pulses `done_i` exactly once, at some cycle after its `read_o` and before its `wb_o`, and that a unit that is not executing never pulses it. The bench meets this with latency stubs. Each stub loads a fixed count on `read_o` and raises `done_i` only when the count reaches one, so the pulse can come only from a started, unfinished unit. Instruction fields are held stable from the first offer until the grant edge.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_ADD = 2'd1,
    CLS_MUL = 2'd2,
    CLS_DIV = 2'd3
  } op_cls_e;
endpackage

// File: rtl/sb_issue.sv
module sb_issue import sb_pkg::*; #(
  parameter int NUM_REGS = 16,
  parameter int NUM_MUL  = 2,
  localparam int RW = $clog2(NUM_REGS),
  localparam int NU = 3 + NUM_MUL,
  localparam int UW = $clog2(NU)
) (
  input  logic                valid_i,
  input  op_cls_e             cls_i,
  input  logic [RW-1:0]       dst_i,
  input  logic [NU-1:0]       busy_i,
  input  logic [NUM_REGS-1:0] pend_i,
  output logic                ready_o,
  output logic [NU-1:0]       grant_o,
  output logic [UW-1:0]       unit_o
);
  logic [NU-1:0] cand, free, pick;

  always_comb begin
    cand = '0;
    unique case (cls_i)
      CLS_INT: cand[0] = 1'b1;
      CLS_ADD: cand[1] = 1'b1;
      CLS_MUL: for (int m = 0; m < NUM_MUL; m++) cand[2+m] = 1'b1;
      CLS_DIV: cand[NU-1] = 1'b1;
      default: cand = '0;
    endcase
  end

  assign free = cand & ~busy_i;

  // lowest idle unit of the class wins
  always_comb begin
    pick   = '0;
    unit_o = '0;
    for (int u = NU - 1; u >= 0; u--) begin
      if (free[u]) begin
        pick    = '0;
        pick[u] = 1'b1;
        unit_o  = UW'(u);
      end
    end
  end

  assign ready_o = (|free) && !pend_i[dst_i];
  assign grant_o = (valid_i && ready_o) ? pick : '0;
endmodule

// File: rtl/sb_regstat.sv
module sb_regstat #(
  parameter int NUM_REGS = 16,
  parameter int NU = 5,
  localparam int RW = $clog2(NUM_REGS),
  localparam int UW = $clog2(NU)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_en_i,
  input  logic [RW-1:0]       set_reg_i,
  input  logic [UW-1:0]       set_unit_i,
  input  logic [NU-1:0]       wb_i,
  input  logic [RW-1:0]       fi_i [NU],
  output logic [NUM_REGS-1:0] pend_o,
  output logic [UW-1:0]       owner_o [NUM_REGS]
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= '0;
      for (int r = 0; r < NUM_REGS; r++) owner_o[r] <= '0;
    end else begin
      for (int u = 0; u < NU; u++)
        if (wb_i[u]) pend_o[fi_i[u]] <= 1'b0;
      if (set_en_i) begin
        pend_o[set_reg_i]  <= 1'b1;
        owner_o[set_reg_i] <= set_unit_i;
      end
    end
  end

  a_r4_no_waw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |-> !pend_o[set_reg_i]);
endmodule

// File: rtl/sb_slot.sv
module sb_slot #(
  parameter int RW = 4,
  parameter int NU = 5,
  parameter int ID = 0,
  localparam int UW = $clog2(NU)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          grant_i,
  input  logic [RW-1:0] dst_i,
  input  logic [RW-1:0] src1_i,
  input  logic [RW-1:0] src2_i,
  input  logic          src1_rdy_i,
  input  logic          src2_rdy_i,
  input  logic [UW-1:0] src1_q_i,
  input  logic [UW-1:0] src2_q_i,
  input  logic [NU-1:0] wb_all_i,
  input  logic          done_i,
  output logic          busy_o,
  output logic          exd_o,
  output logic          read_o,
  output logic [RW-1:0] fi_o,
  output logic [RW-1:0] fj_o,
  output logic [RW-1:0] fk_o,
  output logic          rj_o,
  output logic          rk_o
);
  logic [UW-1:0] qj, qk;
  logic          rd_q;

  assign read_o = busy_o && !rd_q && rj_o && rk_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      exd_o  <= 1'b0;
      rd_q   <= 1'b0;
      rj_o   <= 1'b0;
      rk_o   <= 1'b0;
      fi_o   <= '0;
      fj_o   <= '0;
      fk_o   <= '0;
      qj     <= '0;
      qk     <= '0;
    end else if (grant_i) begin
      busy_o <= 1'b1;
      exd_o  <= 1'b0;
      rd_q   <= 1'b0;
      fi_o   <= dst_i;
      fj_o   <= src1_i;
      fk_o   <= src2_i;
      qj     <= src1_q_i;
      qk     <= src2_q_i;
      rj_o   <= src1_rdy_i;
      rk_o   <= src2_rdy_i;
    end else begin
      // producer broadcast marks a waiting source available
      if (busy_o && !rd_q && !rj_o && wb_all_i[qj]) rj_o <= 1'b1;
      if (busy_o && !rd_q && !rk_o && wb_all_i[qk]) rk_o <= 1'b1;
      if (read_o) begin
        rd_q <= 1'b1;
        rj_o <= 1'b0;
        rk_o <= 1'b0;
      end
      if (done_i && rd_q) exd_o <= 1'b1;
      if (wb_all_i[ID]) begin
        busy_o <= 1'b0;
        exd_o  <= 1'b0;
        rd_q   <= 1'b0;
      end
    end
  end

  a_r9_grant_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> !busy_o);
  a_r6_single_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_o |=> !read_o);
  a_r9_free_on_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_all_i[ID] |=> !busy_o);
endmodule

// File: rtl/sb_wbperm.sv
module sb_wbperm #(
  parameter int RW = 4,
  parameter int NU = 5
) (
  input  logic [NU-1:0] busy_i,
  input  logic [NU-1:0] exd_i,
  input  logic [RW-1:0] fi_i [NU],
  input  logic [RW-1:0] fj_i [NU],
  input  logic [RW-1:0] fk_i [NU],
  input  logic [NU-1:0] rj_i,
  input  logic [NU-1:0] rk_i,
  output logic [NU-1:0] wb_o
);
  for (genvar u = 0; u < NU; u++) begin : g_unit
    logic war;
    always_comb begin
      war = 1'b0;
      for (int f = 0; f < NU; f++) begin
        if (f != u && busy_i[f] &&
            ((rj_i[f] && fj_i[f] == fi_i[u]) || (rk_i[f] && fk_i[f] == fi_i[u])))
          war = 1'b1;
      end
    end
    assign wb_o[u] = exd_i[u] && !war;
  end
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl import sb_pkg::*; #(
  parameter int NUM_REGS = 16,
  parameter int NUM_MUL  = 2,
  localparam int RW = $clog2(NUM_REGS),
  localparam int NU = 3 + NUM_MUL,
  localparam int UW = $clog2(NU)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [1:0]    in_cls_i,
  input  logic [RW-1:0] in_dst_i,
  input  logic [RW-1:0] in_src1_i,
  input  logic [RW-1:0] in_src2_i,
  output logic          in_ready_o,
  output logic [NU-1:0] grant_o,
  output logic [NU-1:0] read_o,
  input  logic [NU-1:0] done_i,
  output logic [NU-1:0] wb_o
);
  logic [NU-1:0]       busy, exd, rj, rk;
  logic [RW-1:0]       fi [NU];
  logic [RW-1:0]       fj [NU];
  logic [RW-1:0]       fk [NU];
  logic [NUM_REGS-1:0] pend;
  logic [UW-1:0]       owner [NUM_REGS];
  logic [UW-1:0]       gnt_unit;
  logic                src1_rdy, src2_rdy;

  sb_issue #(.NUM_REGS(NUM_REGS), .NUM_MUL(NUM_MUL)) u_issue (
    .valid_i (in_valid_i),
    .cls_i   (op_cls_e'(in_cls_i)),
    .dst_i   (in_dst_i),
    .busy_i  (busy),
    .pend_i  (pend),
    .ready_o (in_ready_o),
    .grant_o (grant_o),
    .unit_o  (gnt_unit)
  );

  sb_regstat #(.NUM_REGS(NUM_REGS), .NU(NU)) u_regstat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_en_i   (|grant_o),
    .set_reg_i  (in_dst_i),
    .set_unit_i (gnt_unit),
    .wb_i       (wb_o),
    .fi_i       (fi),
    .pend_o     (pend),
    .owner_o    (owner)
  );

  // a producer writing back in the issue cycle counts as already written
  assign src1_rdy = !pend[in_src1_i] || wb_o[owner[in_src1_i]];
  assign src2_rdy = !pend[in_src2_i] || wb_o[owner[in_src2_i]];

  for (genvar u = 0; u < NU; u++) begin : g_slot
    sb_slot #(.RW(RW), .NU(NU), .ID(u)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .grant_i    (grant_o[u]),
      .dst_i      (in_dst_i),
      .src1_i     (in_src1_i),
      .src2_i     (in_src2_i),
      .src1_rdy_i (src1_rdy),
      .src2_rdy_i (src2_rdy),
      .src1_q_i   (owner[in_src1_i]),
      .src2_q_i   (owner[in_src2_i]),
      .wb_all_i   (wb_o),
      .done_i     (done_i[u]),
      .busy_o     (busy[u]),
      .exd_o      (exd[u]),
      .read_o     (read_o[u]),
      .fi_o       (fi[u]),
      .fj_o       (fj[u]),
      .fk_o       (fk[u]),
      .rj_o       (rj[u]),
      .rk_o       (rk[u])
    );
  end

  sb_wbperm #(.RW(RW), .NU(NU)) u_wbperm (
    .busy_i (busy),
    .exd_i  (exd),
    .fi_i   (fi),
    .fj_i   (fj),
    .fk_i   (fk),
    .rj_i   (rj),
    .rk_i   (rk),
    .wb_o   (wb_o)
  );

  a_r3_grant_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  a_r1_grant_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|grant_o) |-> in_valid_i);
endmodule

// File: tb/tb_sb_ctrl.sv
module tb_sb_ctrl;
  localparam int CLK_P = 10;
  localparam int NU = 5;
  localparam int WD_LIMIT = 150000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid_i = 1'b0;
  logic [1:0] in_cls_i = '0;
  logic [3:0] in_dst_i = '0, in_src1_i = '0, in_src2_i = '0;
  logic       in_ready_o;
  logic [NU-1:0] grant_o, read_o, done_i, wb_o;

  int total = 0, bad = 0, cyc = 0, cur_id = 0;
  int is_c[8], rd_c[8], wb_c[8], gu[8];
  int unit_inst[NU];
  int cnt[NU];

  sb_ctrl dut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic int unit_lat(int u);
    case (u)
      0: return 1;
      1: return 2;
      4: return 6;
      default: return 4;
    endcase
  endfunction

  function automatic int cls_lat(int c);
    case (c)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 6;
    endcase
  endfunction

  // latency stubs for the functional units
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int u = 0; u < NU; u++) cnt[u] <= 0;
    end else begin
      for (int u = 0; u < NU; u++) begin
        if (read_o[u]) cnt[u] <= unit_lat(u);
        else if (cnt[u] > 0) cnt[u] <= cnt[u] - 1;
      end
    end
  end
  always_comb for (int u = 0; u < NU; u++) done_i[u] = (cnt[u] == 1);

  // event monitor, sampled mid-cycle
  always @(negedge clk_i) begin
    if (rst_ni) begin
      for (int u = 0; u < NU; u++) begin
        if (grant_o[u]) begin
          unit_inst[u] = cur_id;
          is_c[cur_id] = cyc;
          gu[cur_id] = u;
        end
        if (read_o[u]) rd_c[unit_inst[u]] = cyc;
        if (wb_o[u]) wb_c[unit_inst[u]] = cyc;
      end
    end
  end

  initial begin
    wait (cyc >= WD_LIMIT);
    bad++;
    total++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic clear_log();
    for (int i = 0; i < 8; i++) begin
      is_c[i] = -1; rd_c[i] = -1; wb_c[i] = -1; gu[i] = -1;
    end
  endtask

  // called right after a rising edge; returns right after the grant edge
  task automatic issue(input int id, input int cls, input int d, input int s1, input int s2);
    cur_id = id;
    in_cls_i = 2'(cls);
    in_dst_i = 4'(d);
    in_src1_i = 4'(s1);
    in_src2_i = 4'(s2);
    in_valid_i = 1'b1;
    forever begin
      @(negedge clk_i);
      if (in_ready_o) break;
    end
    @(posedge clk_i);
    #1;
    in_valid_i = 1'b0;
  endtask

  task automatic settle();
    repeat (40) @(posedge clk_i);
    #1;
  endtask

  initial begin
    clear_log();
    for (int u = 0; u < NU; u++) unit_inst[u] = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    chk("R10 ready", int'(in_ready_o), 1);
    chk("R10 grant", int'(grant_o), 0);
    chk("R10 read", int'(read_o), 0);
    chk("R10 wb", int'(wb_o), 0);
    @(posedge clk_i);
    #1;

    // two-instruction sweep over classes and register overlap patterns
    for (int ca = 0; ca < 4; ca++)
      for (int cb = 0; cb < 4; cb++)
        for (int dk = 0; dk < 3; dk++)
          for (int sk = 0; sk < 2; sk++) begin
            int d2, s2a, blocked, e_is2, e_rd2;
            d2 = (dk == 0) ? 1 : (dk == 1) ? 2 : 5;
            s2a = (sk == 0) ? 1 : 6;
            clear_log();
            issue(0, ca, 1, 2, 3);
            issue(1, cb, d2, s2a, 7);
            settle();
            blocked = ((ca == cb && ca != 2) || d2 == 1) ? 1 : 0;
            chk("R6 read after grant", rd_c[0], is_c[0] + 1);
            chk("R7 wb after done", wb_c[0], rd_c[0] + cls_lat(ca) + 1);
            e_is2 = blocked ? wb_c[0] + 1 : is_c[0] + 1;
            if (ca == cb && ca != 2 && d2 != 1)
              chk("R2 structural hold", is_c[1], e_is2);
            else if (d2 == 1)
              chk("R4 waw hold", is_c[1], e_is2);
            else
              chk("R9 back to back", is_c[1], e_is2);
            e_rd2 = is_c[1] + 1;
            if (s2a == 1 && wb_c[0] + 1 > e_rd2) e_rd2 = wb_c[0] + 1;
            chk("R5 raw read", rd_c[1], e_rd2);
            chk("R7 second wb", wb_c[1], rd_c[1] + cls_lat(cb) + 1);
          end

    // WAR: divide F0; add F10<-F0,F8; integer F8<-F8,F14
    clear_log();
    issue(0, 3, 0, 2, 4);
    issue(1, 1, 10, 0, 8);
    issue(2, 0, 8, 8, 14);
    settle();
    chk("R1 consecutive issue", is_c[2], is_c[1] + 1);
    chk("R5 add waits divide", rd_c[1], wb_c[0] + 1);
    chk("R6 int reads early", rd_c[2], is_c[2] + 1);
    chk("R8 int wb held past add read", wb_c[2], rd_c[1] + 1);
    chk("R8 hold was needed", int'(rd_c[2] + 2 < wb_c[2]), 1);

    // in-order: second divide blocks an independent integer op behind it
    clear_log();
    issue(0, 3, 1, 2, 3);
    issue(1, 3, 4, 2, 3);
    issue(2, 0, 5, 6, 7);
    settle();
    chk("R2 divide busy", is_c[1], wb_c[0] + 1);
    chk("R1 head blocks later", is_c[2], is_c[1] + 1);

    // two multiplies share the class
    clear_log();
    issue(0, 2, 1, 2, 3);
    issue(1, 2, 4, 5, 6);
    issue(2, 2, 7, 8, 9);
    settle();
    chk("R3 first mul unit", gu[0], 2);
    chk("R3 second mul unit", gu[1], 3);
    chk("R3 second mul issue", is_c[1], is_c[0] + 1);
    chk("R2 third mul waits", is_c[2], wb_c[0] + 1);
    chk("R3 third mul unit", gu[2], 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule